// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block gives a host processor byte access to the registers of a line-interface controller. One set of pins serves four bus personalities, chosen by two static strap inputs. The address and data can travel on separate buses or share one multiplexed bus. The strobes can follow either the read/write convention or the data-strobe with read/not-write convention. Every strobe, strap and bus input passes through a two-flop synchroniser into the internal clock domain, and then a small access state machine decodes it.

The state machine has three states. `S_IDLE` waits for an access. It moves to `S_WRITE` when a qualified write strobe appears, or else to `S_READ` when a qualified read strobe appears. `S_WRITE` captures the bus data while the write stays active. It returns to `S_IDLE` when the write ends, and that trailing edge commits the byte. `S_READ` drives the data bus while the read stays active. It returns to `S_IDLE` when the read ends, and that trailing edge clears any status bits the host has just read.

Address 0x00 is a sticky event register, set by any change on the condition inputs. Address 0x01 is the interrupt mask. Address 0x02 returns the live condition inputs. Every other address is a plain byte of storage. The interrupt is an active-high pull-down request, standing for an active-low open-drain line. A test input releases the data bus and the interrupt at once.

Top module: `hostbus_port`

## Requirements
- R1: With `strap_mux` low, the access address is {`ale_as`, `addr_lo[6:0]`}. A written byte is read back from the same 8-bit address and from no other address.
- R2: With `strap_mux` high, the address is taken from `data_in` on a rising edge of `ale_as`, and `addr_lo` is ignored.
- R3: With `strap_moto` low, `rd_ds` low is a read and `wr_rw` low is a write. A write stores `data_in` into the addressed register when the write strobe ends.
- R4: With `strap_moto` high, `wr_rw` high means read and low means write. The data strobe `rd_ds` is active low when `strap_mux` is high and active high when it is low. A write takes effect at the end of the data strobe.
- R5: While `cs_n` is high, a strobe neither changes any register nor drives the data bus.
- R6: `data_oe` is high only during an active read with `cs_n` low and `test_hiz` low. During that read, `data_out` holds the contents of the addressed register.
- R7: Status register 0x00 sets a bit whenever the matching `cond_in` bit changes level. Host writes to it have no effect. When a read of 0x00 ends, the bits that were set at the start of that read are cleared.
- R8: Address 0x01 is a read/write interrupt mask. Address 0x02 reads back the current `cond_in` and ignores writes.
- R9: `irq_low` is high exactly when some status bit and its mask bit are both 1, and `test_hiz` is low.
- R10: `test_hiz` high forces `data_oe` and `irq_low` low.
- R11: After reset all registers read 0, `data_oe` is low and `irq_low` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| strap_mux | input | 1 | 1 = multiplexed address/data bus |
| strap_moto | input | 1 | 1 = data strobe with read/not-write signalling |
| test_hiz | input | 1 | 1 = release all outputs |
| cs_n | input | 1 | Active-low chip select |
| rd_ds | input | 1 | Read strobe or data strobe |
| wr_rw | input | 1 | Write strobe or read/not-write |
| ale_as | input | 1 | Address latch/strobe (multiplexed) or address bit 7 |
| addr_lo | input | 7 | Address bits 6..0 (separate-bus mode) |
| data_in | input | 8 | Bus value seen by the block |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Bus drive enable |
| cond_in | input | 8 | Condition inputs feeding the status register |
| irq_low | output | 1 | 1 = pull the interrupt line low |

## Verification
The assertions assume that the straps change only while no access is in progress and chip select is high. They also assume that address, bus data and read/not-write are held steady for several clocks around each strobe edge, so that the synchronised copies stay aligned. The stimulus changes straps only between transactions and holds each bus phase for at least three clocks. In data-strobe mode it sets read/not-write one clock before the strobe and keeps it one clock after. Condition inputs are toggled only with gaps longer than the synchroniser delay.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } acc_state_t;

    localparam logic [7:0] ADDR_STATUS = 8'h00;
    localparam logic [7:0] ADDR_MASK   = 8'h01;
    localparam logic [7:0] ADDR_COND   = 8'h02;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int          W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST;
            q    <= RST;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode (
    input  logic mux_mode,
    input  logic moto_mode,
    input  logic cs_n_s,
    input  logic rd_ds_s,
    input  logic wr_rw_s,
    output logic acc_rd,
    output logic acc_wr
);
    logic ds_on;
    logic rd_act;
    logic wr_act;

    always_comb begin
        ds_on = mux_mode ? ~rd_ds_s : rd_ds_s;
        if (moto_mode) begin
            rd_act = ds_on & wr_rw_s;
            wr_act = ds_on & ~wr_rw_s;
        end else begin
            rd_act = ~rd_ds_s;
            wr_act = ~wr_rw_s;
        end
        acc_rd = ~cs_n_s & rd_act;
        acc_wr = ~cs_n_s & wr_act;
    end
endmodule

// File: rtl/hbp_regs.sv
module hbp_regs
    import hbp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_commit,
    input  logic          rd_start,
    input  logic          rd_done,
    input  logic [DW-1:0] cond_s,
    output logic [DW-1:0] rdata,
    output logic          irq_raw
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] status;
    logic [DW-1:0] snap;
    logic [DW-1:0] cond_prev;
    logic [DW-1:0] clr_bits;
    logic          is_status;
    logic          is_cond;

    assign is_status = (addr == AW'(ADDR_STATUS));
    assign is_cond   = (addr == AW'(ADDR_COND));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_commit && !is_status && !is_cond) begin
            mem[addr] <= wdata;
        end
    end

    always_comb begin
        clr_bits = (rd_done && is_status) ? snap : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status    <= '0;
            snap      <= '0;
            cond_prev <= '0;
        end else begin
            cond_prev <= cond_s;
            status    <= (status & ~clr_bits) | (cond_s ^ cond_prev);
            if (rd_start) snap <= status;
        end
    end

    always_comb begin
        if (is_status)    rdata = status;
        else if (is_cond) rdata = cond_s;
        else              rdata = mem[addr];
    end

    assign irq_raw = |(status & mem[AW'(ADDR_MASK)]);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> ((status & $past(status)) == $past(status))); // R7
    AST_CLEAR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !is_status) |=> ((status & $past(status)) == $past(status))); // R7
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hbp_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_mux,
    input  logic          strap_moto,
    input  logic          test_hiz,
    input  logic          cs_n,
    input  logic          rd_ds,
    input  logic          wr_rw,
    input  logic          ale_as,
    input  logic [AW-2:0] addr_lo,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic [DW-1:0] cond_in,
    output logic          irq_low
);
    localparam int CW = 3;
    localparam int PW = 2 + 1 + (AW - 1) + DW + DW;

    logic [CW-1:0] ctl_s;
    logic [PW-1:0] pay_s;
    logic          cs_n_s, rd_ds_s, wr_rw_s;
    logic          mux_s, moto_s, ale_s;
    logic [AW-2:0] alo_s;
    logic [DW-1:0] data_s, cond_s;

    hbp_sync #(.W(CW), .RST({CW{1'b1}})) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d({cs_n, rd_ds, wr_rw}), .q(ctl_s));
    hbp_sync #(.W(PW), .RST({PW{1'b0}})) u_sync_pay (
        .clk(clk), .rst_n(rst_n),
        .d({strap_mux, strap_moto, ale_as, addr_lo, data_in, cond_in}), .q(pay_s));

    assign {cs_n_s, rd_ds_s, wr_rw_s}                     = ctl_s;
    assign {mux_s, moto_s, ale_s, alo_s, data_s, cond_s} = pay_s;

    logic acc_rd, acc_wr;

    hbp_decode u_dec (
        .mux_mode(mux_s), .moto_mode(moto_s), .cs_n_s(cs_n_s),
        .rd_ds_s(rd_ds_s), .wr_rw_s(wr_rw_s), .acc_rd(acc_rd), .acc_wr(acc_wr));

    acc_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (acc_wr) st_nx = S_WRITE;
                     else if (acc_rd) st_nx = S_READ;
            S_READ:  if (!acc_rd) st_nx = S_IDLE;
            S_WRITE: if (!acc_wr) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    logic wr_commit, rd_start, rd_done, drive;

    always_comb begin
        wr_commit = 1'b0;
        rd_start  = 1'b0;
        rd_done   = 1'b0;
        drive     = 1'b0;
        unique case (st)
            S_IDLE:  rd_start  = acc_rd & ~acc_wr;
            S_READ: begin
                drive   = acc_rd;
                rd_done = ~acc_rd;
            end
            S_WRITE: wr_commit = ~acc_wr;
            default: ;
        endcase
    end

    logic          ale_prev;
    logic          ale_rise;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign ale_rise = ale_s & ~ale_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_prev <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else begin
            ale_prev <= ale_s;
            if (st == S_IDLE) begin
                if (mux_s) begin
                    if (ale_rise) addr_q <= data_s[AW-1:0];
                end else begin
                    addr_q <= {ale_s, alo_s};
                end
            end
            if (st == S_WRITE && acc_wr) wdata_q <= data_s;
        end
    end

    logic irq_raw;

    hbp_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .wdata(wdata_q),
        .wr_commit(wr_commit), .rd_start(rd_start), .rd_done(rd_done),
        .cond_s(cond_s), .rdata(data_out), .irq_raw(irq_raw));

    assign data_oe = drive & ~test_hiz;
    assign irq_low = irq_raw & ~test_hiz;

    AST_TEST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        test_hiz |-> (!data_oe && !irq_low)); // R10
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !cs_n_s); // R6
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_commit, rd_start, rd_done})); // R3
    AST_WRITE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(acc_wr)); // R5
    AST_MUX_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_s && !ale_rise) |=> $stable(addr_q)); // R2
endmodule

// File: tb/sim_hostbus_port.sv
module sim_hostbus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_mux = 1'b0, strap_moto = 1'b0, test_hiz = 1'b0;
    logic       cs_n = 1'b1, rd_ds = 1'b1, wr_rw = 1'b1, ale_as = 1'b0;
    logic [6:0] addr_lo = '0;
    logic [7:0] data_in = '0, cond_in = '0;
    logic [7:0] data_out;
    logic       data_oe, irq_low;

    int total = 0;
    int bad   = 0;
    logic [7:0] mir [256];

    always #4 clk = ~clk;

    hostbus_port u0 (
        .clk(clk), .rst_n(rst_n), .strap_mux(strap_mux), .strap_moto(strap_moto),
        .test_hiz(test_hiz), .cs_n(cs_n), .rd_ds(rd_ds), .wr_rw(wr_rw),
        .ale_as(ale_as), .addr_lo(addr_lo), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .cond_in(cond_in), .irq_low(irq_low));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_idle();
        cs_n   = 1'b1;
        wr_rw  = 1'b1;
        rd_ds  = (strap_moto && !strap_mux) ? 1'b0 : 1'b1;
        ale_as = 1'b0;
    endtask

    task automatic set_mode(input bit m, input bit t);
        strap_mux  = m;
        strap_moto = t;
        set_idle();
        cyc(5);
    endtask

    task automatic access(input bit wr, input bit sel, input logic [7:0] a,
                          input logic [7:0] wd, output logic [7:0] rv, output bit oe);
        logic [31:0] r;
        r = $urandom;
        cs_n = 1'b1;
        if (strap_mux) begin
            data_in = a;
            addr_lo = r[6:0];
            ale_as  = 1'b1;
            cyc(4);
            ale_as  = 1'b0;
            cyc(3);
        end else begin
            addr_lo = a[6:0];
            ale_as  = a[7];
            data_in = r[15:8];
            cyc(3);
        end
        cs_n = !sel;
        if (wr) data_in = wd;
        cyc(1);
        if (strap_moto) begin
            wr_rw = !wr;
            cyc(1);
            rd_ds = strap_mux ? 1'b0 : 1'b1;
        end else if (wr) wr_rw = 1'b0;
        else rd_ds = 1'b0;
        cyc(6);
        rv = data_out;
        oe = data_oe;
        if (strap_moto) begin
            rd_ds = strap_mux ? 1'b1 : 1'b0;
            cyc(1);
            wr_rw = 1'b1;
        end else begin
            rd_ds = 1'b1;
            wr_rw = 1'b1;
        end
        cyc(6);
        cs_n = 1'b1;
        ale_as = 1'b0;
        cyc(2);
    endtask

    function automatic string mode_tag(input bit m, input bit t);
        if (t) return m ? "R4 R2" : "R4 R1";
        return m ? "R3 R2" : "R3 R1";
    endfunction

    function automatic logic [7:0] pick_addr(input logic [31:0] r);
        logic [7:0] a;
        a = r[7:0];
        if (a == 8'h00 || a == 8'h02) a = a + 8'h03;
        return a;
    endfunction

    initial begin
        logic [7:0] rv;
        bit oe;
        logic [31:0] r;
        void'($urandom(32'd1357));
        for (int i = 0; i < 256; i++) mir[i] = 8'h00;
        set_mode(1'b0, 1'b0);
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        chk(data_oe == 1'b0, "R11 oe", data_oe, 0);
        chk(irq_low == 1'b0, "R11 irq", irq_low, 0);
        access(1'b0, 1'b1, 8'h77, 8'h00, rv, oe);
        chk(rv == 8'h00 && oe, "R11 reg", rv, 0);

        // directed R1: bit 7 of the address comes from ale_as
        access(1'b1, 1'b1, 8'h85, 8'h5A, rv, oe); mir[8'h85] = 8'h5A;
        access(1'b0, 1'b1, 8'h05, 8'h00, rv, oe);
        chk(rv == mir[8'h05], "R1 alias", rv, mir[8'h05]);
        access(1'b0, 1'b1, 8'h85, 8'h00, rv, oe);
        chk(rv == 8'h5A, "R1 high", rv, 8'h5A);

        // random traffic over all four personalities
        for (int k = 0; k < 48; k++) begin
            logic [7:0] a, d;
            bit m, t, sel;
            r = $urandom;
            m = r[0]; t = r[1]; sel = (r[4:2] != 3'd0);
            if (k % 6 == 0) set_mode(m, t);
            a = pick_addr($urandom);
            d = r[15:8];
            access(1'b1, sel, a, d, rv, oe);
            if (sel) mir[a] = d;
            access(1'b0, 1'b1, a, 8'h00, rv, oe);
            chk(oe == 1'b1, "R6 oe", oe, 1);
            chk(rv == mir[a], sel ? mode_tag(strap_mux, strap_moto) : "R5 write",
                rv, mir[a]);
        end

        // R5: read with chip select high must not drive
        set_mode(1'b1, 1'b1);
        access(1'b0, 1'b0, 8'h10, 8'h00, rv, oe);
        chk(oe == 1'b0, "R5 no drive", oe, 0);

        // status, mask and condition
        set_mode(1'b0, 1'b0);
        access(1'b1, 1'b1, 8'h01, 8'h05, rv, oe);
        access(1'b0, 1'b1, 8'h01, 8'h00, rv, oe);
        chk(rv == 8'h05, "R8 mask", rv, 5);
        chk(irq_low == 1'b0, "R9 quiet", irq_low, 0);
        cond_in = 8'h01;
        cyc(8);
        chk(irq_low == 1'b1, "R9 raise", irq_low, 1);
        test_hiz = 1'b1;
        cyc(1);
        chk(irq_low == 1'b0, "R10 irq", irq_low, 0);
        test_hiz = 1'b0;
        cyc(1);
        access(1'b0, 1'b1, 8'h00, 8'h00, rv, oe);
        chk(rv == 8'h01, "R7 read", rv, 1);
        chk(irq_low == 1'b0, "R9 cleared", irq_low, 0);
        access(1'b0, 1'b1, 8'h00, 8'h00, rv, oe);
        chk(rv == 8'h00, "R7 clear", rv, 0);
        cond_in = 8'h03;
        cyc(8);
        chk(irq_low == 1'b0, "R9 masked", irq_low, 0);
        access(1'b1, 1'b1, 8'h00, 8'hFF, rv, oe);
        access(1'b1, 1'b1, 8'h02, 8'hF0, rv, oe);
        access(1'b0, 1'b1, 8'h02, 8'h00, rv, oe);
        chk(rv == 8'h03, "R8 cond", rv, 3);
        access(1'b0, 1'b1, 8'h00, 8'h00, rv, oe);
        chk(rv == 8'h02, "R7 write ignored", rv, 2);
        cond_in = 8'h02;
        cyc(8);
        chk(irq_low == 1'b1, "R9 fall event", irq_low, 1);

        // R10: test input releases the bus during a read
        test_hiz = 1'b1;
        access(1'b0, 1'b1, 8'h01, 8'h00, rv, oe);
        chk(oe == 1'b0, "R10 bus", oe, 0);
        test_hiz = 1'b0;
        cyc(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule